// File: doc/BRIEF.md
# Nonlinear Shift Register Full-Period Verifier

The block decides whether one candidate feedback function gives a binary shift register of order N the longest period such a register can have, 2^N−1 states. The feedback function is the sum over GF(2) of a linear part and an optional quadratic term. The linear part is the parity of a tap mask applied to the state. The quadratic term is the product of the state bits that a second mask selects. Both masks and the order are presented at the same time as a start pulse.

From a fixed seed the block advances the register once per clock and counts the steps. It stops early, with a fail result, when the seed comes back before the full count. Otherwise it runs exactly 2^N−1 steps and passes when the state has then returned to the seed. A one-cycle done pulse marks the end of a run. The verdict and the step number at which the run stopped remain visible until the next start. A host that sweeps candidate masks starts one run per candidate and keeps the ones that pass.

Top module: `nlfsr_period_checker`

## Requirements
- R1: After reset, busy, done, pass and stop_count are all zero.
- R2: Each run starts from state 1 (only bit 0 set). Bit k of lin_mask selects state bit k. The linear feedback part is the XOR of all selected bits.
- R3: The quadratic feedback part is 1 only when nl_mask has at least one bit set below the order and every state bit it selects there is 1. A zero nl_mask gives 0. The feedback bit is the XOR of the linear and quadratic parts.
- R4: One step rotates the low N state bits left by one position, moving bit N−1 into bit 0, and XORs the feedback bit into bit 0. Mask bits at position N and above have no effect on the result.
- R5: When the seed does not reappear early, the run ends after exactly 2^N−1 steps with stop_count = 2^N−1. pass is 1 exactly when the state then equals the seed.
- R6: When the state equals the seed after step k with k < 2^N−1, the run ends at once with pass = 0 and stop_count = k.
- R7: One step is taken per clock. done is a single-cycle pulse that follows the cycle that accepted start by stop_count clock cycles.
- R8: start is ignored while busy is high. Masks and order are captured when start is accepted, and the run uses only those values.
- R9: pass and stop_count are cleared when start is accepted and then hold their end-of-run values until the next accepted start.
- R10: An order below 2 is run as order 2. An order above MAX_ORDER is run as MAX_ORDER.
- R11: The step counter is MAX_ORDER+1 bits wide and never passes the step limit 2^N−1 while a run is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the presented masks and order |
| lin_mask | input | MAX_ORDER | Linear tap mask, bit k selects state bit k |
| nl_mask | input | MAX_ORDER | Quadratic term mask, the selected bits are multiplied |
| order | input | $clog2(MAX_ORDER+1) | Register order N requested |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Full period confirmed for the last run |
| stop_count | output | MAX_ORDER+1 | Step number at which the last run stopped |

## Verification
On every cycle the assertions check the control skeleton: the seed at the first running cycle, a step counter that rises by one per cycle and stays below its limit, and state bits above the order held at zero. They also check captured parameters that do not move during a run, a done that lasts one cycle, an early stop that never reports a pass, and results that stay put between runs. Whether the feedback arithmetic is right, that is, whether the parity, the product, the rotation and the order clamp give the correct period for a given mask pair, only shows in the bench's exhaustive sweeps over small orders. Each run there is compared against a period computed step by step in the bench. The ignored mid-run start and the end-of-run hold are also shown only by directed scenarios.

// File: rtl/nlfsr_pkg.sv
package nlfsr_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // Bring a requested order into the supported range [2, max_order].
  function automatic int unsigned clamp_order(input int unsigned req,
                                              input int unsigned max_order);
    if (req < 2) return 2;
    if (req > max_order) return max_order;
    return req;
  endfunction

endpackage

// File: rtl/nlfsr_feedback.sv
module nlfsr_feedback #(
  parameter int W = 32
) (
  input  logic [W-1:0] state,
  input  logic [W-1:0] lin_taps,
  input  logic [W-1:0] quad_sel,
  input  logic [W-1:0] len_mask,
  output logic         lin_bit,
  output logic         quad_bit,
  output logic         fb_bit
);

  // Parity of the tapped state bits.
  function automatic logic tap_parity(input logic [W-1:0] s,
                                      input logic [W-1:0] taps);
    return ^(s & taps);
  endfunction

  // Product of all selected state bits; an empty selection yields 0.
  function automatic logic sel_product(input logic [W-1:0] s,
                                       input logic [W-1:0] sel);
    return (|sel) && ((s & sel) == sel);
  endfunction

  logic [W-1:0] lin_eff;
  logic [W-1:0] quad_eff;

  assign lin_eff  = lin_taps & len_mask;
  assign quad_eff = quad_sel & len_mask;

  assign lin_bit  = tap_parity(state, lin_eff);
  assign quad_bit = sel_product(state, quad_eff);
  assign fb_bit   = lin_bit ^ quad_bit;

endmodule

// File: rtl/nlfsr_stepper.sv
module nlfsr_stepper #(
  parameter int W     = 32,
  parameter int ORD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_seed,
  input  logic             advance,
  input  logic [ORD_W-1:0] run_order,
  input  logic             fb_bit,
  output logic [W-1:0]     state,
  output logic [W-1:0]     next_state,
  output logic [W-1:0]     len_mask
);

  localparam logic [W-1:0] SEED = W'(1);

  logic [W-1:0] top_sel;
  logic         top_bit;

  // Per-bit length mask and top-bit selector for the active order.
  for (genvar k = 0; k < W; k++) begin : g_len
    assign len_mask[k] = (ORD_W'(k) < run_order);
    assign top_sel[k]  = (ORD_W'(k + 1) == run_order);
  end

  assign top_bit = |(state & top_sel);

  // Rotate left within the active length, feedback folded into bit 0.
  for (genvar k = 0; k < W; k++) begin : g_next
    if (k == 0) begin : g_low
      assign next_state[k] = top_bit ^ fb_bit;
    end else begin : g_up
      assign next_state[k] = state[k-1] & len_mask[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '0;
    end else if (load_seed) begin
      state <= SEED;
    end else if (advance) begin
      state <= next_state;
    end
  end

endmodule

// File: rtl/nlfsr_step_counter.sv
module nlfsr_step_counter #(
  parameter int CNT_W = 33,
  parameter int ORD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [ORD_W-1:0] run_order,
  output logic [CNT_W-1:0] step_count,
  output logic [CNT_W-1:0] step_next,
  output logic [CNT_W-1:0] step_limit,
  output logic             last_step
);

  // Number of distinct nonzero states for the given order.
  function automatic logic [CNT_W-1:0] full_period(input logic [ORD_W-1:0] n);
    return (CNT_W'(1) << n) - CNT_W'(1);
  endfunction

  assign step_limit = full_period(run_order);
  assign step_next  = step_count + CNT_W'(1);
  assign last_step  = (step_next == step_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_count <= '0;
    end else if (clear) begin
      step_count <= '0;
    end else if (advance) begin
      step_count <= step_next;
    end
  end

endmodule

// File: rtl/nlfsr_period_checker.sv
module nlfsr_period_checker #(
  parameter  int MAX_ORDER = 32,
  localparam int CNT_W     = MAX_ORDER + 1,
  localparam int ORD_W     = $clog2(MAX_ORDER + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [MAX_ORDER-1:0] lin_mask,
  input  logic [MAX_ORDER-1:0] nl_mask,
  input  logic [ORD_W-1:0]     order,
  output logic                 busy,
  output logic                 done,
  output logic                 pass,
  output logic [CNT_W-1:0]     stop_count
);

  import nlfsr_pkg::*;

  localparam int W = MAX_ORDER;
  localparam logic [W-1:0] SEED = W'(1);

  phase_t           phase;
  logic [W-1:0]     run_lin;
  logic [W-1:0]     run_nl;
  logic [ORD_W-1:0] run_order;
  logic [ORD_W-1:0] order_clamped;

  // Named internal events, also observed by the bound checker.
  logic             start_accept;
  logic             stepping;
  logic             seed_hit;
  logic             finish_run;
  logic [W-1:0]     cur_state;
  logic [W-1:0]     next_state;
  logic [W-1:0]     len_mask;
  logic             lin_bit;
  logic             quad_bit;
  logic             fb_bit;
  logic [CNT_W-1:0] step_count;
  logic [CNT_W-1:0] step_next;
  logic [CNT_W-1:0] step_limit;
  logic             last_step;

  assign order_clamped = ORD_W'(clamp_order(int'(order), MAX_ORDER));
  assign start_accept  = start && (phase == PH_IDLE);
  assign stepping      = (phase == PH_RUN);
  assign seed_hit      = (next_state == SEED);
  assign finish_run    = stepping && (seed_hit || last_step);
  assign busy          = stepping;

  nlfsr_feedback #(.W(W)) u_feedback (
    .state    (cur_state),
    .lin_taps (run_lin),
    .quad_sel (run_nl),
    .len_mask (len_mask),
    .lin_bit  (lin_bit),
    .quad_bit (quad_bit),
    .fb_bit   (fb_bit)
  );

  nlfsr_stepper #(.W(W), .ORD_W(ORD_W)) u_stepper (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_seed  (start_accept),
    .advance    (stepping),
    .run_order  (run_order),
    .fb_bit     (fb_bit),
    .state      (cur_state),
    .next_state (next_state),
    .len_mask   (len_mask)
  );

  nlfsr_step_counter #(.CNT_W(CNT_W), .ORD_W(ORD_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_accept),
    .advance    (stepping),
    .run_order  (run_order),
    .step_count (step_count),
    .step_next  (step_next),
    .step_limit (step_limit),
    .last_step  (last_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      run_lin    <= '0;
      run_nl     <= '0;
      run_order  <= ORD_W'(2);
      done       <= 1'b0;
      pass       <= 1'b0;
      stop_count <= '0;
    end else begin
      done <= 1'b0;
      if (start_accept) begin
        phase      <= PH_RUN;
        run_lin    <= lin_mask;
        run_nl     <= nl_mask;
        run_order  <= order_clamped;
        pass       <= 1'b0;
        stop_count <= '0;
      end else if (finish_run) begin
        phase      <= PH_IDLE;
        done       <= 1'b1;
        pass       <= last_step && seed_hit;
        stop_count <= step_next;
      end
    end
  end

endmodule

// File: rtl/nlfsr_period_checker_sva.sv
module nlfsr_period_checker_sva #(
  parameter int MAX_ORDER = 32,
  parameter int CNT_W     = MAX_ORDER + 1,
  parameter int ORD_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 pass,
  input logic [CNT_W-1:0]     stop_count,
  input logic [MAX_ORDER-1:0] cur_state,
  input logic [MAX_ORDER-1:0] len_mask,
  input logic [CNT_W-1:0]     step_count,
  input logic [CNT_W-1:0]     step_limit,
  input logic [ORD_W-1:0]     run_order
);

  assert_seed_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> (cur_state == MAX_ORDER'(1)));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_state & ~len_mask) == '0));

  assert_early_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (stop_count < step_limit)) |-> !pass);

  assert_step_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (step_count == $past(step_count) + 1'b1));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_order_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(run_order));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(start)) |-> ($stable(pass) && $stable(stop_count)));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_count < step_limit));

endmodule

bind nlfsr_period_checker nlfsr_period_checker_sva #(
  .MAX_ORDER (MAX_ORDER),
  .CNT_W     (CNT_W),
  .ORD_W     (ORD_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .stop_count (stop_count),
  .cur_state  (cur_state),
  .len_mask   (len_mask),
  .step_count (step_count),
  .step_limit (step_limit),
  .run_order  (run_order)
);

// File: tb/nlfsr_period_checker_test.sv
`timescale 1ns/1ps
module nlfsr_period_checker_test;

  localparam int MAXO  = 32;
  localparam int CW    = MAXO + 1;
  localparam int OW    = $clog2(MAXO + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [MAXO-1:0] lin_mask = '0;
  logic [MAXO-1:0] nl_mask = '0;
  logic [OW-1:0]   order = '0;
  logic            busy, done, pass;
  logic [CW-1:0]   stop_count;

  int checks = 0;
  int failures = 0;
  longint unsigned cycle_no = 0;
  bit watchdog_hit = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cycle_no++;

  nlfsr_period_checker #(.MAX_ORDER(MAXO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .lin_mask(lin_mask),
    .nl_mask(nl_mask), .order(order), .busy(busy), .done(done),
    .pass(pass), .stop_count(stop_count)
  );

  task automatic check(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent period model: walk the register until the seed or the limit.
  function automatic void model(input int n, input longint unsigned lin,
                                input longint unsigned nl,
                                output bit ok, output longint unsigned cnt);
    longint unsigned width_mask = (64'd1 << n) - 1;
    longint unsigned s = 1;
    longint unsigned l = lin & width_mask;
    longint unsigned q = nl & width_mask;
    ok = 0;
    cnt = 0;
    for (longint unsigned k = 1; k <= width_mask; k++) begin
      bit lp = bit'($countones(s & l) % 2);
      bit qp = (q != 0) && ((s & q) == q);
      longint unsigned rot = ((s << 1) & width_mask) | ((s >> (n - 1)) & 1);
      s = rot ^ longint'(lp ^ qp);
      if (s == 1 || k == width_mask) begin
        ok = (s == 1) && (k == width_mask);
        cnt = k;
        return;
      end
    end
  endfunction

  function automatic int eff_order(input int req);
    if (req < 2) return 2;
    if (req > MAXO) return MAXO;
    return req;
  endfunction

  // Launch one run and compare with the model; optional mid-run start poke.
  task automatic run_case(input int req, input longint unsigned lin,
                          input longint unsigned nl, input string tag,
                          input bit poke_mid, input bit check_clear);
    bit exp_ok;
    longint unsigned exp_cnt;
    longint unsigned cycles = 0;
    longint unsigned bound;
    model(eff_order(req), lin, nl, exp_ok, exp_cnt);
    bound = exp_cnt + 20;
    @(negedge clk);
    lin_mask = MAXO'(lin);
    nl_mask  = MAXO'(nl);
    order    = OW'(req);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (check_clear)
      check(busy && !pass && stop_count == 0, "R9 clear at start",
            longint'(stop_count), 0);
    while (!done && cycles < bound) begin
      @(negedge clk);
      cycles++;
      if (poke_mid && cycles == 2) begin
        lin_mask = '0; nl_mask = '0; order = OW'(2); start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    if (!done) begin
      check(0, {tag, " done missing"}, cycles, exp_cnt);
      return;
    end
    check(longint'(stop_count) == exp_cnt, {tag, " stop_count"},
          longint'(stop_count), exp_cnt);
    check(pass == exp_ok, {tag, " pass"}, longint'(pass), longint'(exp_ok));
    check(cycles == exp_cnt, "R7 latency", cycles, exp_cnt);
    @(negedge clk);
    check(!done && !busy, "R7 done single cycle", longint'(done), 0);
  endtask

  initial begin
    #2_000_000;
    watchdog_hit = 1;
  end

  initial begin : main
    fork
      begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !pass && stop_count == 0, "R1 reset state",
              longint'(stop_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 idle after reset", longint'(busy), 0);

        // R5 known full-period tap set: x^4+x^3+1 style, expects 15
        run_case(4, 64'h1, 0, "R5 full period n4", 0, 1);
        check(pass == 1 && stop_count == 15, "R5 directed pass",
              longint'(stop_count), 15);
        // R6 pure rotation returns at step N
        run_case(4, 0, 0, "R6 early return n4", 0, 1);
        check(pass == 0 && stop_count == 4, "R6 directed abort",
              longint'(stop_count), 4);
        // R4 mask bits at and above N are ignored
        run_case(4, 64'h1F1, 64'hF00, "R4 upper mask bits", 0, 0);
        check(pass == 1 && stop_count == 15, "R4 upper bits no effect",
              longint'(stop_count), 15);
        // R3 product not parity: nl 0x3 from seed 1
        run_case(4, 64'h1, 64'h3, "R3 product term", 0, 0);
        // R8 start during a run is ignored
        run_case(4, 64'h1, 0, "R8 start ignored", 1, 0);
        check(pass == 1 && stop_count == 15, "R8 result unchanged",
              longint'(stop_count), 15);
        // R9 results hold while idle
        repeat (6) @(negedge clk);
        check(pass == 1 && stop_count == 15, "R9 hold after done",
              longint'(stop_count), 15);
        // R10 order clamps
        run_case(0, 0, 0, "R10 order low clamp", 0, 0);
        check(stop_count == 2, "R10 low clamp count", longint'(stop_count), 2);
        run_case(63, 0, 0, "R10 order high clamp", 0, 0);
        check(stop_count == 32, "R10 high clamp count", longint'(stop_count), 32);
        // R11 early abort at the largest order with a wide counter
        run_case(32, 0, 64'h3, "R11 order 32 run", 0, 0);

        // R2 R3 R4 R5 R6 sweeps: every mask pair for small orders
        for (int n = 3; n <= 4; n++)
          for (int l = 0; l < (1 << n); l++)
            for (int q = 0; q < (1 << n); q++)
              run_case(n, longint'(l), longint'(q), "R2 sweep small", 0, 0);
        for (int l = 0; l < 32; l++) begin
          run_case(5, longint'(l), 0, "R5 sweep n5 linear", 0, 0);
          for (int i = 0; i < 5; i++)
            for (int j = i + 1; j < 5; j++)
              run_case(5, longint'(l), (64'd1 << i) | (64'd1 << j),
                       "R3 sweep n5 pair", 0, 0);
        end
        for (int l = 1; l < 256; l += 37)
          run_case(8, longint'(l), 64'h0C, "R6 sweep n8", 0, 0);
      end
      begin
        wait (watchdog_hit);
      end
    join_any
    if (watchdog_hit) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycle_no);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule